// File: doc/BRIEF.md
# Conditional next-PC selection unit

This unit resolves where program flow goes after a jump instruction. A five-bit jump-type code selects one of nineteen jump forms: unconditional jumps to a label, jump with link, fourteen flag-conditional jumps, register-indirect jumps with or without link, and return through the link register. The unit evaluates the carry (C), zero (Z), sign (S) and overflow (V) flags against the selected condition. It produces the next program counter, a taken indicator, and a link-register write request carrying the value to store.

The unit takes one jump per clock, qualified by `jmp_vld`, and presents the registered result one cycle later. A jump that is not taken, including any unused code, advances to the current PC plus the instruction size. Instruction fetch and pipeline flushing belong to the surrounding core.

Top module: `brnx_next_pc`

## Requirements
- R1: While reset is asserted and until the first accepted jump, `taken_o` and `lr_we_o` are 0, and `npc_o` and `lr_wdata_o` are 0.
- R2: Codes 0 (always) and 1 (always, with link) are always taken, and `npc_o` becomes `label_tgt`.
- R3: Single-flag codes jump to `label_tgt` when their condition holds. The conditions are: 2 when V=0, 3 when V=1, 4 when S=0, 5 when S=1, 6 when Z=0, 7 when Z=1, 8 when C=0 (unsigned higher-or-equal), and 9 when C=1 (unsigned lower).
- R4: Signed codes jump to `label_tgt` when their condition holds. The conditions are: 10 when (S^V)=0, 11 when (S^V)=1, 12 when (Z|(S^V))=0, and 13 when (Z|(S^V))=1.
- R5: Unsigned compound codes jump to `label_tgt` when their condition holds. The conditions are: 14 when (C|Z)=0, and 15 when (C|Z)=1.
- R6: When a jump is not taken, `npc_o` is `pc_i` + INSN_BYTES (default 4), and `taken_o` and `lr_we_o` are 0.
- R7: Codes 1 and 17 assert `lr_we_o` with `lr_wdata_o` equal to `pc_i`. Every other code leaves `lr_we_o` at 0.
- R8: Codes 16 and 17 are always taken, and `npc_o` becomes `reg_tgt`.
- R9: Code 18 is always taken, and `npc_o` becomes `lr_val`.
- R10: Codes 19 to 31 are never taken and never write the link register.
- R11: Results appear on the outputs one clock after the accepting edge. While `jmp_vld` is 0, `taken_o` and `lr_we_o` read 0, and `npc_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| jmp_vld | input | 1 | A jump is presented this cycle |
| jmp_type | input | 5 | Jump-type code |
| pc_i | input | ADDR_W | Current program counter |
| label_tgt | input | ADDR_W | Label target address |
| reg_tgt | input | ADDR_W | Register target value |
| lr_val | input | ADDR_W | Current link register value |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_v | input | 1 | Overflow flag |
| npc_o | output | ADDR_W | Next program counter |
| taken_o | output | 1 | Jump taken |
| lr_we_o | output | 1 | Link register write enable |
| lr_wdata_o | output | ADDR_W | Value to store into the link register |

## Verification
The bench sweeps all 32 codes against all 16 flag combinations at several PC values. This catches a swapped polarity inside a condition pair, which would make an equal test jump on not-equal. It also catches carry read the wrong way for the unsigned forms, and an OR replaced by XOR in the signed greater and unsigned higher forms. The unused codes 19 to 31 are checked for a leak into taken or link behaviour. Idle cycles between jumps are checked as well, to show that a stale taken or link-write does not linger, and that a return does not fetch from the label rather than from the link register.

// File: rtl/brnx_pkg.sv
package brnx_pkg;
  localparam int unsigned CODE_W = 5;

  typedef enum logic [CODE_W-1:0] {
    JT_ALWAYS  = 5'd0,
    JT_LINK    = 5'd1,
    JT_VCLR    = 5'd2,
    JT_VSET    = 5'd3,
    JT_SCLR    = 5'd4,
    JT_SSET    = 5'd5,
    JT_ZCLR    = 5'd6,
    JT_ZSET    = 5'd7,
    JT_CCLR    = 5'd8,
    JT_CSET    = 5'd9,
    JT_SGE     = 5'd10,
    JT_SLT     = 5'd11,
    JT_SGT     = 5'd12,
    JT_SLE     = 5'd13,
    JT_UHI     = 5'd14,
    JT_ULS     = 5'd15,
    JT_REG     = 5'd16,
    JT_REGLINK = 5'd17,
    JT_RET     = 5'd18
  } jtype_e;

  typedef enum logic [1:0] {
    SRC_SEQ   = 2'd0,
    SRC_LABEL = 2'd1,
    SRC_REG   = 2'd2,
    SRC_LINK  = 2'd3
  } tsrc_e;

  // number of flag-condition pairs occupying codes 2..15
  localparam int unsigned N_PAIRS = 7;
endpackage

// File: rtl/brnx_cond_eval.sv
module brnx_cond_eval
  import brnx_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              fc,
  input  logic              fz,
  input  logic              fs,
  input  logic              fv,
  output logic              cond_true
);
  localparam int unsigned PAIR_IDX_W = 3;

  logic [N_PAIRS-1:0] pred;
  logic [N_PAIRS-1:0] pair_hit;
  logic               sv_x;

  assign sv_x = fs ^ fv;

  // predicate of each pair; odd code = predicate true, even = predicate false
  always_comb begin
    pred[0] = fv;
    pred[1] = fs;
    pred[2] = fz;
    pred[3] = fc;
    pred[4] = sv_x;
    pred[5] = fz | sv_x;
    pred[6] = fc | fz;
  end

  genvar gp;
  generate
    for (gp = 0; gp < N_PAIRS; gp++) begin : g_pair
      localparam logic [PAIR_IDX_W-1:0] PIDX = PAIR_IDX_W'(gp + 1);
      assign pair_hit[gp] = (code[CODE_W-1] == 1'b0) &&
                            (code[PAIR_IDX_W:1] == PIDX) &&
                            (pred[gp] == code[0]);
    end
  endgenerate

  always_comb begin
    unique case (code)
      JT_ALWAYS, JT_LINK, JT_REG, JT_REGLINK, JT_RET: cond_true = 1'b1;
      default:                                        cond_true = |pair_hit;
    endcase
  end

  // R10
  unused_code_chk: assert final ((code <= CODE_W'(JT_RET)) || !cond_true);
endmodule

// File: rtl/brnx_target_sel.sv
module brnx_target_sel
  import brnx_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic [CODE_W-1:0] code,
  input  logic              cond_true,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] label_tgt,
  input  logic [ADDR_W-1:0] reg_tgt,
  input  logic [ADDR_W-1:0] lr_val,
  output logic [ADDR_W-1:0] npc,
  output logic              taken,
  output logic              link_we
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  tsrc_e             src;
  logic              wants_link;
  logic [ADDR_W-1:0] seq_pc;

  assign seq_pc = pc + STEP;

  always_comb begin
    src        = SRC_SEQ;
    wants_link = 1'b0;
    if (cond_true) begin
      unique case (code)
        JT_LINK:    begin src = SRC_LABEL; wants_link = 1'b1; end
        JT_REG:     src = SRC_REG;
        JT_REGLINK: begin src = SRC_REG; wants_link = 1'b1; end
        JT_RET:     src = SRC_LINK;
        default:    src = SRC_LABEL;
      endcase
    end
  end

  always_comb begin
    unique case (src)
      SRC_LABEL: npc = label_tgt;
      SRC_REG:   npc = reg_tgt;
      SRC_LINK:  npc = lr_val;
      default:   npc = seq_pc;
    endcase
  end

  assign taken   = (src != SRC_SEQ);
  assign link_we = wants_link;

  // R6
  seq_step_chk: assert final (taken || (npc == seq_pc));
  // R7
  link_taken_chk: assert final (!link_we || taken);
endmodule

// File: rtl/brnx_next_pc.sv
module brnx_next_pc
  import brnx_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jmp_vld,
  input  logic [CODE_W-1:0] jmp_type,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] label_tgt,
  input  logic [ADDR_W-1:0] reg_tgt,
  input  logic [ADDR_W-1:0] lr_val,
  input  logic              flag_c,
  input  logic              flag_z,
  input  logic              flag_s,
  input  logic              flag_v,
  output logic [ADDR_W-1:0] npc_o,
  output logic              taken_o,
  output logic              lr_we_o,
  output logic [ADDR_W-1:0] lr_wdata_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  logic              cond_true;
  logic [ADDR_W-1:0] npc_c;
  logic              taken_c;
  logic              link_c;

  brnx_cond_eval u_cond (
    .code      (jmp_type),
    .fc        (flag_c),
    .fz        (flag_z),
    .fs        (flag_s),
    .fv        (flag_v),
    .cond_true (cond_true)
  );

  brnx_target_sel #(
    .ADDR_W     (ADDR_W),
    .INSN_BYTES (INSN_BYTES)
  ) u_sel (
    .code      (jmp_type),
    .cond_true (cond_true),
    .pc        (pc_i),
    .label_tgt (label_tgt),
    .reg_tgt   (reg_tgt),
    .lr_val    (lr_val),
    .npc       (npc_c),
    .taken     (taken_c),
    .link_we   (link_c)
  );

  // next-state
  logic [ADDR_W-1:0] npc_d, lrw_d;
  logic              taken_d, lrwe_d, addr_en;

  always_comb begin
    addr_en = jmp_vld;
    npc_d   = npc_c;
    lrw_d   = pc_i;
    taken_d = jmp_vld & taken_c;
    lrwe_d  = jmp_vld & link_c;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      taken_o <= 1'b0;
      lr_we_o <= 1'b0;
    end else begin
      taken_o <= taken_d;
      lr_we_o <= lrwe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      npc_o      <= '0;
      lr_wdata_o <= '0;
    end else if (addr_en) begin
      npc_o      <= npc_d;
      lr_wdata_o <= lrw_d;
    end
  end

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !jmp_vld |=> (!taken_o && !lr_we_o && $stable(npc_o)));
  // R9
  ret_link_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (jmp_vld && jmp_type == CODE_W'(JT_RET)) |=> (taken_o && npc_o == $past(lr_val)));
  // R7
  link_value_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (jmp_vld && (jmp_type == CODE_W'(JT_LINK) || jmp_type == CODE_W'(JT_REGLINK)))
      |=> (lr_we_o && lr_wdata_o == $past(pc_i)));
  // R10
  unused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (jmp_vld && jmp_type > CODE_W'(JT_RET)) |=> (!taken_o && !lr_we_o));
  // R2
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (jmp_vld && jmp_type <= CODE_W'(JT_LINK)) |=> (taken_o && npc_o == $past(label_tgt)));
endmodule

// File: tb/brnx_next_pc_tb.sv
module brnx_next_pc_tb;
  localparam int unsigned AW = 32;
  localparam int unsigned IB = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          jmp_vld;
  logic [4:0]    jmp_type;
  logic [AW-1:0] pc_i, label_tgt, reg_tgt, lr_val;
  logic          flag_c, flag_z, flag_s, flag_v;
  logic [AW-1:0] npc_o, lr_wdata_o;
  logic          taken_o, lr_we_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  brnx_next_pc #(.ADDR_W(AW), .INSN_BYTES(IB)) u_dut (
    .clk(clk), .rst_n(rst_n), .jmp_vld(jmp_vld), .jmp_type(jmp_type),
    .pc_i(pc_i), .label_tgt(label_tgt), .reg_tgt(reg_tgt), .lr_val(lr_val),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v),
    .npc_o(npc_o), .taken_o(taken_o), .lr_we_o(lr_we_o), .lr_wdata_o(lr_wdata_o)
  );

  function automatic string tag_of(input int code);
    if (code <= 1)       return "R2";
    else if (code <= 9)  return "R3";
    else if (code <= 13) return "R4";
    else if (code <= 15) return "R5";
    else if (code <= 17) return "R8";
    else if (code == 18) return "R9";
    else                 return "R10";
  endfunction

  function automatic bit ref_cond(input int code, input bit c, z, s, v);
    case (code)
      0, 1:    return 1'b1;
      2:       return !v;
      3:       return v;
      4:       return !s;
      5:       return s;
      6:       return !z;
      7:       return z;
      8:       return !c;
      9:       return c;
      10:      return (s ^ v) == 1'b0;
      11:      return (s ^ v) == 1'b1;
      12:      return (z | (s ^ v)) == 1'b0;
      13:      return (z | (s ^ v)) == 1'b1;
      14:      return (c | z) == 1'b0;
      15:      return (c | z) == 1'b1;
      16, 17, 18: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_one(input int code, input bit c, z, s, v,
                         input logic [AW-1:0] pc);
    bit            tk;
    bit            lw;
    logic [AW-1:0] en;
    @(negedge clk);
    jmp_vld = 1'b1; jmp_type = code[4:0];
    pc_i = pc; label_tgt = pc ^ 32'h0F0F_0F00; reg_tgt = ~pc & 32'hFFFF_FFFC;
    lr_val = pc + 32'h0001_0000;
    flag_c = c; flag_z = z; flag_s = s; flag_v = v;
    tk = ref_cond(code, c, z, s, v);
    lw = (code == 1 || code == 17);
    if (!tk)                      en = pc + IB;
    else if (code == 16 || code == 17) en = reg_tgt;
    else if (code == 18)          en = lr_val;
    else                          en = label_tgt;
    @(negedge clk);
    check(tag_of(code), "taken", AW'(taken_o), AW'(tk));
    check(tk ? tag_of(code) : "R6", "npc", npc_o, en);
    check("R7", "lr_we", AW'(lr_we_o), AW'(lw));
    if (lw) check("R7", "lr_wdata", lr_wdata_o, pc);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] pcs [3];
    logic [AW-1:0] held;
    pcs[0] = 32'h0000_1000; pcs[1] = 32'hFFFF_FFFC; pcs[2] = 32'h8765_4320;
    rst_n = 1'b0; jmp_vld = 1'b0; jmp_type = '0;
    pc_i = '0; label_tgt = '0; reg_tgt = '0; lr_val = '0;
    flag_c = 0; flag_z = 0; flag_s = 0; flag_v = 0;
    repeat (3) @(negedge clk);
    check("R1", "taken in reset", AW'(taken_o), '0);
    check("R1", "lr_we in reset", AW'(lr_we_o), '0);
    check("R1", "npc in reset", npc_o, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "taken after release", AW'(taken_o), '0);
    check("R1", "lr_wdata after release", lr_wdata_o, '0);

    for (int p = 0; p < 3; p++)
      for (int code = 0; code < 32; code++)
        for (int f = 0; f < 16; f++)
          run_one(code, f[3], f[2], f[1], f[0], pcs[p]);

    // R11: idle after a taken link jump clears taken and lr_we, holds npc
    run_one(1, 0, 0, 0, 0, 32'h0000_2000);
    held = npc_o;
    @(negedge clk);
    jmp_vld = 1'b0; jmp_type = 5'd18; lr_val = 32'hDEAD_BEE0;
    @(negedge clk);
    check("R11", "idle taken", AW'(taken_o), '0);
    check("R11", "idle lr_we", AW'(lr_we_o), '0);
    check("R11", "idle npc hold", npc_o, held);
    @(negedge clk);
    check("R11", "idle npc hold 2", npc_o, held);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule